// File: doc/BRIEF.md
# Early-Present-Late Bit Recovery Unit

This unit turns an oversampled stream of hard 0/1 decisions from a frequency demodulator into recovered bits. A new raw decision arrives on every clock. Once per bit (or chip) period, the unit emits one recovered bit together with a single-cycle valid strobe. A mode input picks the period: 32 samples per bit for the 1 Mbps mode, or 16 samples per chip for the 2 Mchip/s mode.

Three windowed integrators each score the most recent period of samples. Their windows are staggered by one clock. Each integrator counts an input 1 as +1 and an input 0 as −1, so the size of its sum shows how cleanly its window lines up with one bit. A down-counter marks each sampling instant. At that instant the strongest integrator supplies the bit, from the sign of its sum. The same integrator also sets the next counter reload to one period, one period plus a clock, or one period minus a clock, which pulls the sampling phase toward the data.

A free-running count of recovered bits is kept for each mode and can be read as status. A synchronous clear empties the integrators, zeroes both counts and restarts the sample counter.

Top module: `epl_cdr`

## Requirements
- R1: While reset is held, `bit_vld` is 0 and both bit counts read 0.
- R2: With the mode held steady, two consecutive strobes are P-1, P or P+1 clocks apart, where P is 32 when `mode`=0 and 16 when `mode`=1. A strobe is never high for two clocks in a row.
- R3: The recovered bit is 1 when the chosen integrator has more ones than zeros in its window, and 0 otherwise. A constant-1 input gives 1s and a constant-0 input gives 0s.
- R4: When no integrator is strictly stronger than the present one (a tie counts), the next strobe comes exactly P clocks later. With a constant input and a full history, strobes are therefore exactly P apart.
- R5: For a square-wave input with half period P and any phase offset below P/2, exactly one strobe falls in each bit. After 8 strobes the recovered bits alternate, and once the unit has locked the strobes are exactly P apart.
- R6: Each strobe adds one to `nbits_slow` when `mode`=0, or to `nbits_fast` when `mode`=1. The other count is left unchanged.
- R7: A clear empties the integrators, zeroes both counts and suppresses the strobe. The first strobe follows exactly P clocks after the clock edge that samples the clear.
- R8: When the newest window (late) is strictly the strongest, the next strobe comes P+1 clocks later. For a constant-1 input just after a clear, this makes the second strobe P+1 clocks after the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of integrators, sample counter and bit counts |
| mode | input | 1 | 0: 32 samples per bit; 1: 16 samples per chip |
| din | input | 1 | Raw hard decision, one per clock |
| bit_out | output | 1 | Last recovered bit |
| bit_vld | output | 1 | One-cycle strobe marking a new `bit_out` |
| nbits_slow | output | CNT_W | Bits recovered in mode 0 |
| nbits_fast | output | CNT_W | Chips recovered in mode 1 |

## Verification
The strobe is registered, so it appears in the clock after the sample counter reaches zero. The first strobe after a clear therefore lands P edges after the clearing edge, and each later strobe lands one reload value plus one edge after the previous one. The monitor samples on falling edges and measures every gap in clocks, counting from the falling edge at which the clear is seen. For each strobe it pops an expected item that gives the bit value (fixed, alternating or don't-care) and the allowed gap: exactly P, exactly P+1, or within one clock of P. The bit counts are read one edge after the last expected strobe, when they must equal the number of expected items.

// File: rtl/epl_cdr.sv
module epl_cdr #(
  parameter int SPB_SLOW = 32,
  parameter int SPB_FAST = 16,
  parameter int CNT_W    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             mode,
  input  logic             din,
  output logic             bit_out,
  output logic             bit_vld,
  output logic [CNT_W-1:0] nbits_slow,
  output logic [CNT_W-1:0] nbits_fast
);
  localparam int HW = SPB_SLOW + 2;
  localparam int PW = $clog2(SPB_SLOW + 3);

  logic [HW-1:0] hist;
  logic [HW-1:0] msk;
  logic [PW-1:0] per, cnt, reload;
  logic [PW-1:0] ones_e, ones_p, ones_l;
  logic [PW:0]   mag_e, mag_p, mag_l;
  logic          win_e, win_l, dec, tick;

  function automatic logic [PW:0] magn(input logic [PW-1:0] o, input logic [PW-1:0] p);
    logic [PW:0] a, b;
    a = {o, 1'b0};
    b = {1'b0, p};
    return (a >= b) ? a - b : b - a;
  endfunction

  assign per    = mode ? PW'(SPB_FAST) : PW'(SPB_SLOW);
  assign msk    = (HW'(1) << per) - HW'(1);
  assign ones_l = PW'($countones(hist & msk));
  assign ones_p = PW'($countones(hist & (msk << 1)));
  assign ones_e = PW'($countones(hist & (msk << 2)));
  assign mag_l  = magn(ones_l, per);
  assign mag_p  = magn(ones_p, per);
  assign mag_e  = magn(ones_e, per);

  assign win_e  = (mag_e > mag_p) && (mag_e > mag_l);
  assign win_l  = (mag_l > mag_p) && (mag_l > mag_e);
  assign dec    = win_e ? ({ones_e, 1'b0} > {1'b0, per}) :
                  win_l ? ({ones_l, 1'b0} > {1'b0, per}) :
                          ({ones_p, 1'b0} > {1'b0, per});
  assign reload = win_l ? per : (win_e ? per - PW'(2) : per - PW'(1));
  assign tick   = (cnt == '0) && !clr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   hist <= '0;
    else if (clr) hist <= '0;
    else          hist <= {hist[HW-2:0], din};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    cnt <= per - PW'(1);
    else if (clr)  cnt <= per - PW'(1);
    else if (tick) cnt <= reload;
    else           cnt <= cnt - PW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_out    <= 1'b0;
      bit_vld    <= 1'b0;
      nbits_slow <= '0;
      nbits_fast <= '0;
    end else if (clr) begin
      bit_vld    <= 1'b0;
      nbits_slow <= '0;
      nbits_fast <= '0;
    end else begin
      bit_vld <= tick;
      if (tick) begin
        bit_out <= dec;
        if (mode) nbits_fast <= nbits_fast + CNT_W'(1);
        else      nbits_slow <= nbits_slow + CNT_W'(1);
      end
    end

  logic [7:0] gcnt;
  logic       gval, mode_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      gcnt   <= '0;
      gval   <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      mode_q <= mode;
      gcnt   <= bit_vld ? 8'd1 : ((gcnt == 8'hff) ? gcnt : gcnt + 8'd1);
      gval   <= (clr || (mode != mode_q)) ? 1'b0 : (bit_vld ? 1'b1 : gval);
    end

  p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |=> !bit_vld);

  p_gap_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && gval) |-> (int'(gcnt) >= int'(per) - 1 && int'(gcnt) <= int'(per) + 1));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!bit_vld && nbits_slow == '0 && nbits_fast == '0));

  p_count_slow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && !$past(mode)) |-> (nbits_slow == $past(nbits_slow) + CNT_W'(1) && $stable(nbits_fast)));

  p_count_fast_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && $past(mode)) |-> (nbits_fast == $past(nbits_fast) + CNT_W'(1) && $stable(nbits_slow)));

  p_count_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_vld && !$past(clr)) |-> ($stable(nbits_slow) && $stable(nbits_fast)));
endmodule

// File: tb/sim_epl_cdr.sv
module sim_epl_cdr;
  localparam int PS = 32;
  localparam int PF = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        mode = 1'b0;
  logic        din = 1'b0;
  logic        bit_out, bit_vld;
  logic [31:0] nbits_slow, nbits_fast;

  epl_cdr u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .mode(mode), .din(din),
    .bit_out(bit_out), .bit_vld(bit_vld),
    .nbits_slow(nbits_slow), .nbits_fast(nbits_fast)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int last_t = 0;
  bit first = 1'b0;
  bit prev_bit = 1'b0;
  int q[$];
  int gap, pm, it, bc, gc;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops one expected item per strobe
  always @(negedge clk) begin
    cyc++;
    if (clr) begin
      last_t = cyc + 1;
      first  = 1'b1;
    end else if (bit_vld) begin
      gap    = cyc - last_t;
      pm     = mode ? PF : PS;
      last_t = cyc;
      if (q.size() > 0) begin
        it = q.pop_front();
        bc = it / 4;
        gc = it % 4;
        if (bc < 2)       chk(int'(bit_out) == bc, "R3 bit value", int'(bit_out), bc);
        else if (bc == 2) chk(bit_out != prev_bit, "R5 alternation", int'(bit_out), int'(!prev_bit));
        if (gc == 1) begin
          if (first) chk(gap == pm, "R7 first strobe after clear", gap, pm);
          else       chk(gap == pm, "R4 tie spacing", gap, pm);
        end else if (gc == 2) chk(gap >= pm - 1 && gap <= pm + 1, "R2 spacing window", gap, pm);
        else if (gc == 3) chk(gap == pm + 1, "R8 late winner lengthens", gap, pm + 1);
      end
      prev_bit = bit_out;
      first    = 1'b0;
    end
  end

  function automatic logic pat(input int kind, input int t, input int off, input int p);
    if (kind == 0) return 1'b0;
    if (kind == 1) return 1'b1;
    return 1'(((t + off) / p) % 2);
  endfunction

  task automatic run_phase(input bit m, input int kind, input int off);
    int p, n, t;
    p = m ? PF : PS;
    t = 0;
    @(posedge clk); #1;
    mode = m;
    clr  = 1'b1;
    din  = pat(kind, t, off, p);
    if (kind == 2) begin
      for (int i = 0; i < 8; i++)  q.push_back(3 * 4 + 0);
      for (int i = 0; i < 16; i++) q.push_back(2 * 4 + 2);
      for (int i = 0; i < 8; i++)  q.push_back(2 * 4 + 1);
      n = 32;
    end else begin
      for (int i = 0; i < 6; i++)
        q.push_back(kind * 4 + ((kind == 1 && i == 1) ? 3 : 1));
      n = 6;
    end
    do begin
      @(posedge clk); #1;
      clr = 1'b0;
      t++;
      din = pat(kind, t, off, p);
    end while (q.size() > 0);
    if (m) begin
      chk(int'(nbits_fast) == n, "R6 fast count", int'(nbits_fast), n);
      chk(nbits_slow == 0, "R6 slow count untouched", int'(nbits_slow), 0);
    end else begin
      chk(int'(nbits_slow) == n, "R6 slow count", int'(nbits_slow), n);
      chk(nbits_fast == 0, "R6 fast count untouched", int'(nbits_fast), 0);
    end
  endtask

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    chk(bit_vld == 1'b0, "R1 strobe in reset", int'(bit_vld), 0);
    chk(nbits_slow == 0, "R1 slow count in reset", int'(nbits_slow), 0);
    chk(nbits_fast == 0, "R1 fast count in reset", int'(nbits_fast), 0);
    rst_n = 1'b1;
    run_phase(1'b0, 1, 0);
    run_phase(1'b0, 0, 0);
    run_phase(1'b1, 1, 0);
    run_phase(1'b1, 0, 0);
    run_phase(1'b0, 2, 0);
    run_phase(1'b0, 2, 5);
    run_phase(1'b0, 2, 11);
    run_phase(1'b0, 2, 15);
    run_phase(1'b1, 2, 0);
    run_phase(1'b1, 2, 3);
    run_phase(1'b1, 2, 7);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule